// File: doc/BRIEF.md
# HDLC Transmit Engine with Threshold FIFO

This block turns host-written bytes into a bit-serial HDLC stream. The host pushes payload bytes into a small FIFO and tags the final byte of each packet with an end-of-message bit. The engine wraps each packet in flags, applies zero-bit stuffing, and can append a 16-bit frame check sequence. A bit inserter outside the block takes one bit per request strobe.

A packet starts at a flag boundary, either once a tagged final byte sits in the FIFO or once the FIFO fill reaches a programmable upper threshold. When the FIFO runs dry before the tagged byte arrives, the packet is aborted.

Four sticky event flags record these events: FIFO full, write overrun, transmit underrun, and fill dropping below a lower threshold. Each flag has its own interrupt enable. A FIFO-clear input empties the FIFO for initialisation.

Top module: `hdlc_tx`

## Requirements
- R1: After reset `bit_out` is 0 and `flags` is 0. While no packet is being sent the engine emits the flag byte 0x7E back to back, least significant bit first.
- R2: Each cycle with `bit_req` high produces the next line bit on `bit_out` from the following cycle on. Without a strobe, `bit_out` holds its value. Bytes go out least significant bit first.
- R3: A packet starts only at the end of a flag byte, only while `tx_enable` is high, and only when the FIFO holds a byte tagged end-of-message or its fill is at least `upper_thr`. While `tx_enable` is low, only flags are sent.
- R4: After five consecutive ones in payload or check bytes, a zero is inserted. This includes a run that ends on the last check bit. Flag and abort bytes are never stuffed.
- R5: With `crc_enable` high, the tagged final byte is followed by a check sequence. The check is CRC-16 with reflected polynomial 0x8408 and preset 0xFFFF, computed over the payload bits and sent complemented, low byte first. With `crc_enable` low, the closing flag follows the final byte directly.
- R6: If a byte without the end-of-message tag finishes while the FIFO is empty, `flags[1]` (underrun) is set. Eight ones are then sent, followed by flags.
- R7: `flags[3]` (full) is set when an accepted write brings the fill to DEPTH.
- R8: A write while the FIFO holds DEPTH bytes is dropped and sets `flags[2]` (overrun).
- R9: `flags[0]` (low fill) is set when a read takes the fill from at least `lower_thr` to below `lower_thr`.
- R10: Flags are sticky until a 1 on the matching `flag_clr` bit clears them. `irq` is high when any flag is set whose `irq_enable` bit is set.
- R11: While `fifo_clear` is high the FIFO is emptied, writes are ignored and no packet starts.
- R12: A host write and a serializer read of the FIFO in the same cycle both take effect, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Allows packets to start |
| fifo_clear | input | 1 | Empties the FIFO while high |
| crc_enable | input | 1 | Appends the check sequence |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host payload byte |
| wr_eom | input | 1 | Tags the written byte as the last of its packet |
| upper_thr | input | CW | Fill level that starts a packet |
| lower_thr | input | CW | Fill level for the low-fill flag |
| irq_enable | input | 4 | Per-flag interrupt enables (bit3 full, bit2 overrun, bit1 underrun, bit0 low) |
| flag_clr | input | 4 | Write-one-to-clear for `flags` |
| bit_req | input | 1 | Bit request from the inserter |
| bit_out | output | 1 | Serial line bit |
| flags | output | 4 | Sticky event flags |
| irq | output | 1 | Interrupt request |

## Verification
The host write path and the serializer's byte fetch meet whenever a write lands in the cycle where a byte boundary strobe pops the FIFO. The bench provokes this by starting a packet on the upper threshold and then issuing writes together with strobes at a pace close to the byte rate, so that some writes fall on pop cycles. The captured bit stream is then compared, bit by bit, with a frame the bench builds from the written bytes, including stuffing and the check sequence. A lost or repeated byte shows up as a mismatch, and the underrun flag must stay clear.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;

    localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
    localparam logic [7:0]  ABORT_BYTE   = 8'hFF;
    localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
    localparam logic [2:0]  STUFF_RUN    = 3'd5;

    typedef enum logic [2:0] {
        S_FLAG,
        S_DATA,
        S_FCS_LO,
        S_FCS_HI,
        S_ABORT
    } ser_state_e;

    typedef struct packed {
        logic       eom;
        logic [7:0] data;
    } fifo_word_t;

    // bit3 full, bit2 overrun, bit1 underrun, bit0 low fill
    typedef struct packed {
        logic full;
        logic ovr;
        logic udr;
        logic low;
    } irq_vec_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        crc_step = (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY_REV : 16'h0000);
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
`timescale 1ns/1ps
module hdlc_tx_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       push,
    input  fifo_word_t push_word,
    input  logic       pop,
    output fifo_word_t pop_word,
    output logic [CW-1:0] count,
    output logic [CW-1:0] eom_count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fifo_word_t mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic do_push, do_pop;

    assign do_push  = push && (count < CW'(DEPTH));
    assign do_pop   = pop && (count != '0);
    assign pop_word = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !clr && !rst) begin
            mem[wr_ptr] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            eom_count <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
            eom_count <= eom_count + CW'(do_push && push_word.eom)
                                   - CW'(do_pop && pop_word.eom);
        end
    end
endmodule

// File: rtl/hdlc_tx_irq.sv
`timescale 1ns/1ps
module hdlc_tx_irq
    import hdlc_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t events,
    input  logic [3:0] clr,
    input  logic [3:0] enable,
    output logic [3:0] flags,
    output logic     irq
);
    logic [3:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr) | events;
        end
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & enable);
endmodule

// File: rtl/hdlc_tx_ser.sv
`timescale 1ns/1ps
module hdlc_tx_ser
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_req,
    input  logic       crc_en,
    input  logic       start_ok,
    input  logic       fifo_nonempty,
    input  fifo_word_t head,
    output logic       pop,
    output logic       underrun,
    output logic       bit_out
);
    ser_state_e  state;
    logic [7:0]  sh;
    logic [2:0]  cnt;
    logic [2:0]  ones;
    logic [15:0] crc;
    logic [15:0] crc_n;
    logic        cur_eom;
    logic        stuff, byte_end, counted;

    assign stuff    = (ones == STUFF_RUN);
    assign byte_end = bit_req && !stuff && (cnt == 3'd7);
    assign counted  = (state == S_DATA) || (state == S_FCS_LO) || (state == S_FCS_HI);
    assign crc_n    = crc_step(crc, sh[0]);

    assign pop = byte_end &&
                 (((state == S_FLAG) && start_ok) ||
                  ((state == S_DATA) && !cur_eom && fifo_nonempty));
    assign underrun = byte_end && (state == S_DATA) && !cur_eom && !fifo_nonempty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_FLAG;
            sh      <= FLAG_BYTE;
            cnt     <= '0;
            ones    <= '0;
            crc     <= CRC_PRESET;
            cur_eom <= 1'b0;
            bit_out <= 1'b0;
        end else if (bit_req) begin
            if (stuff) begin
                bit_out <= 1'b0;
                ones    <= '0;
            end else begin
                bit_out <= sh[0];
                if (counted) begin
                    ones <= sh[0] ? ones + 3'd1 : 3'd0;
                end
                if (state == S_DATA) begin
                    crc <= crc_n;
                end
                if (cnt != 3'd7) begin
                    sh  <= sh >> 1;
                    cnt <= cnt + 3'd1;
                end else begin
                    cnt <= '0;
                    unique case (state)
                        S_FLAG: begin
                            if (pop) begin
                                state   <= S_DATA;
                                sh      <= head.data;
                                cur_eom <= head.eom;
                                crc     <= CRC_PRESET;
                                ones    <= '0;
                            end else begin
                                sh <= FLAG_BYTE;
                            end
                        end
                        S_DATA: begin
                            if (cur_eom) begin
                                if (crc_en) begin
                                    state <= S_FCS_LO;
                                    sh    <= ~crc_n[7:0];
                                end else begin
                                    state <= S_FLAG;
                                    sh    <= FLAG_BYTE;
                                end
                            end else if (pop) begin
                                sh      <= head.data;
                                cur_eom <= head.eom;
                            end else begin
                                state <= S_ABORT;
                                sh    <= ABORT_BYTE;
                            end
                        end
                        S_FCS_LO: begin
                            state <= S_FCS_HI;
                            sh    <= ~crc[15:8];
                        end
                        S_FCS_HI, S_ABORT: begin
                            state <= S_FLAG;
                            sh    <= FLAG_BYTE;
                        end
                        default: begin
                            state <= S_FLAG;
                            sh    <= FLAG_BYTE;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_tx.sv
`timescale 1ns/1ps
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_enable,
    input  logic          fifo_clear,
    input  logic          crc_enable,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_eom,
    input  logic [CW-1:0] upper_thr,
    input  logic [CW-1:0] lower_thr,
    input  logic [3:0]    irq_enable,
    input  logic [3:0]    flag_clr,
    input  logic          bit_req,
    output logic          bit_out,
    output logic [3:0]    flags,
    output logic          irq
);
    fifo_word_t    wr_word, head;
    logic [CW-1:0] fifo_cnt, eom_cnt;
    logic          push_req, push_acc, pop, underrun;
    logic          nonempty, start_ok;
    logic [CW:0]   cnt_after;
    irq_vec_t      ev;

    assign wr_word.eom  = wr_eom;
    assign wr_word.data = wr_data;

    assign push_req = wr_en && !fifo_clear;
    assign push_acc = push_req && (fifo_cnt < CW'(DEPTH));
    assign nonempty = (fifo_cnt != '0) && !fifo_clear;
    assign start_ok = tx_enable && nonempty &&
                      ((eom_cnt != '0) || (fifo_cnt >= upper_thr));

    assign cnt_after = {1'b0, fifo_cnt} - (CW+1)'(pop) + (CW+1)'(push_acc);

    assign ev.full = push_acc && !pop && (fifo_cnt == CW'(DEPTH - 1));
    assign ev.ovr  = push_req && (fifo_cnt == CW'(DEPTH));
    assign ev.udr  = underrun;
    assign ev.low  = pop && (fifo_cnt >= lower_thr) && (cnt_after < {1'b0, lower_thr});

    hdlc_tx_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (fifo_clear),
        .push      (push_acc),
        .push_word (wr_word),
        .pop       (pop),
        .pop_word  (head),
        .count     (fifo_cnt),
        .eom_count (eom_cnt)
    );

    hdlc_tx_ser u_ser (
        .clk           (clk),
        .rst           (rst),
        .bit_req       (bit_req),
        .crc_en        (crc_enable),
        .start_ok      (start_ok),
        .fifo_nonempty (nonempty),
        .head          (head),
        .pop           (pop),
        .underrun      (underrun),
        .bit_out       (bit_out)
    );

    hdlc_tx_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .events (ev),
        .clr    (flag_clr),
        .enable (irq_enable),
        .flags  (flags),
        .irq    (irq)
    );
endmodule

// File: rtl/hdlc_tx_chk.sv
`timescale 1ns/1ps
module hdlc_tx_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          bit_req,
    input logic          bit_out,
    input logic          wr_en,
    input logic          fifo_clear,
    input logic [3:0]    flag_clr,
    input logic [3:0]    flags,
    input logic [CW-1:0] fifo_cnt
);
    // R2: the line bit only moves on a strobe
    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !bit_req |=> $stable(bit_out));

    // R7: fill never exceeds the FIFO depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CW'(DEPTH));

    // R8: a write into a full FIFO raises the overrun flag
    a_r8_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !fifo_clear && fifo_cnt == CW'(DEPTH)) |=> flags[2]);

    // R10: flags not being cleared stay set
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

    // R11: clearing empties the FIFO
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (rst)
        fifo_clear |=> (fifo_cnt == '0));
endmodule

bind hdlc_tx hdlc_tx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_req    (bit_req),
    .bit_out    (bit_out),
    .wr_en      (wr_en),
    .fifo_clear (fifo_clear),
    .flag_clr   (flag_clr),
    .flags      (flags),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/hdlc_tx_test.sv
`timescale 1ns/1ps
module hdlc_tx_test;
    localparam int DEPTH = 16;
    localparam int CW    = 5;

    // {4'b000,crc}, len, bytes (byte i at [8i+:8])
    localparam logic [39:0] VEC [4] = '{
        {4'h1, 4'd1, 32'h0000_00FF},
        {4'h1, 4'd4, 32'h7C3E_F0FF},
        {4'h0, 4'd3, 32'h00F8_1F55},
        {4'h1, 4'd2, 32'h0000_0180}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, tx_enable, fifo_clear, crc_enable, wr_en, wr_eom, bit_req;
    logic [7:0] wr_data;
    logic [CW-1:0] upper_thr, lower_thr;
    logic [3:0] irq_enable, flag_clr, flags;
    logic bit_out, irq;

    hdlc_tx #(.DEPTH(DEPTH), .CW(CW)) uut (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .fifo_clear(fifo_clear),
        .crc_enable(crc_enable), .wr_en(wr_en), .wr_data(wr_data), .wr_eom(wr_eom),
        .upper_thr(upper_thr), .lower_thr(lower_thr), .irq_enable(irq_enable),
        .flag_clr(flag_clr), .bit_req(bit_req), .bit_out(bit_out),
        .flags(flags), .irq(irq)
    );

    int errors = 0;
    int checks = 0;
    logic got [0:1023];
    int ngot;
    logic exp_b [0:1023];
    int nexp;
    int exp_ones;
    logic [7:0] pkt [16];
    int plen;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_req = 1'b0; wr_en = 1'b0; wr_eom = 1'b0; wr_data = 8'h00;
        flag_clr = 4'h0; fifo_clear = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        ngot = 0;
    endtask

    task automatic write_byte(input logic [7:0] d, input logic e);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_eom = e;
        @(negedge clk);
        wr_en = 1'b0; wr_eom = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        bit_req = 1'b1;
        @(negedge clk);
        bit_req = 1'b0;
        got[ngot] = bit_out;
        ngot++;
    endtask

    task automatic strobe_wr(input logic [7:0] d, input logic e);
        @(negedge clk);
        bit_req = 1'b1; wr_en = 1'b1; wr_data = d; wr_eom = e;
        @(negedge clk);
        bit_req = 1'b0; wr_en = 1'b0; wr_eom = 1'b0;
        got[ngot] = bit_out;
        ngot++;
    endtask

    function automatic logic [7:0] grp(input int k);
        logic [7:0] g;
        for (int j = 0; j < 8; j++) g[j] = got[k + j];
        return g;
    endfunction

    function automatic bit all_flags();
        for (int k = 0; k + 8 <= ngot; k += 8)
            if (grp(k) != 8'h7E) return 1'b0;
        return 1'b1;
    endfunction

    task automatic exp_raw(input logic b);
        exp_b[nexp] = b;
        nexp++;
    endtask

    task automatic exp_stuffed(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            exp_raw(v[i]);
            if (v[i]) exp_ones++; else exp_ones = 0;
            if (exp_ones == 5) begin
                exp_raw(1'b0);
                exp_ones = 0;
            end
        end
    endtask

    task automatic exp_plain(input logic [7:0] v);
        for (int i = 0; i < 8; i++) exp_raw(v[i]);
    endtask

    function automatic logic [15:0] fcs_of();
        logic [15:0] c = 16'hFFFF;
        for (int b = 0; b < plen; b++) begin
            c ^= {8'h00, pkt[b]};
            for (int i = 0; i < 8; i++)
                c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    // frame = stuffed payload [+ check], then a closing flag
    task automatic build_frame(input bit with_fcs);
        logic [15:0] f;
        nexp = 0; exp_ones = 0;
        for (int b = 0; b < plen; b++) exp_stuffed(pkt[b]);
        if (with_fcs) begin
            f = fcs_of();
            exp_stuffed(f[7:0]);
            exp_stuffed(f[15:8]);
        end
        exp_plain(8'h7E);
    endtask

    task automatic compare_frame(input string req, input string what);
        int k = 0;
        int bad = -1;
        while (k + 8 <= ngot && grp(k) == 8'h7E) k += 8;
        for (int i = 0; i < nexp; i++)
            if ((k + i >= ngot || got[k + i] !== exp_b[i]) && bad < 0) bad = i;
        check(bad < 0 && k >= 8, req, what, bad, -1);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        tx_enable = 1'b0; crc_enable = 1'b0; upper_thr = CW'(DEPTH); lower_thr = '0;
        irq_enable = 4'hF;
        do_reset();

        // R1 reset state
        check(bit_out === 1'b0, "R1", "bit_out after reset", bit_out, 0);
        check(flags === 4'h0, "R1", "flags after reset", flags, 0);
        check(irq === 1'b0, "R10", "irq after reset", irq, 0);
        irq_enable = 4'h0;

        // vector table: R2, R4, R5 frame contents
        for (int v = 0; v < 4; v++) begin
            do_reset();
            tx_enable = 1'b1;
            crc_enable = VEC[v][36];
            plen = int'(VEC[v][35:32]);
            for (int b = 0; b < plen; b++) pkt[b] = VEC[v][8*b +: 8];
            for (int b = 0; b < plen; b++) write_byte(pkt[b], b == plen - 1);
            for (int s = 0; s < 100; s++) strobe();
            build_frame(crc_enable);
            compare_frame(crc_enable ? "R5" : "R4", $sformatf("frame vector %0d (R2 R3)", v));
        end

        // R3 disabled: only flags; R11 clear then enable: still only flags
        do_reset();
        tx_enable = 1'b0;
        write_byte(8'h55, 1'b1);
        for (int s = 0; s < 40; s++) strobe();
        check(all_flags(), "R3", "no start while disabled", 0, 1);
        @(negedge clk); fifo_clear = 1'b1;
        @(negedge clk); fifo_clear = 1'b0;
        tx_enable = 1'b1;
        ngot = 0;
        for (int s = 0; s < 40; s++) strobe();
        check(all_flags(), "R11", "cleared FIFO sends nothing", 0, 1);
        check(all_flags(), "R1", "idle line carries flags", 0, 1);

        // R3 upper threshold start, R6 underrun abort
        do_reset();
        tx_enable = 1'b1; crc_enable = 1'b1; upper_thr = 5'd3; irq_enable = 4'b0010;
        write_byte(8'h0F, 1'b0);
        write_byte(8'hA5, 1'b0);
        for (int s = 0; s < 32; s++) strobe();
        check(all_flags(), "R3", "below upper threshold stays idle", 0, 1);
        write_byte(8'h3C, 1'b0);
        for (int s = 0; s < 60; s++) strobe();
        nexp = 0; exp_ones = 0;
        exp_stuffed(8'h0F); exp_stuffed(8'hA5); exp_stuffed(8'h3C);
        exp_plain(8'hFF); exp_plain(8'h7E);
        compare_frame("R6", "threshold start then abort");
        check(flags[1] === 1'b1, "R6", "underrun flag", flags, 2);
        check(irq === 1'b1, "R10", "underrun irq enabled", irq, 1);

        // R7 full, R8 overrun, R10 masking and clear
        do_reset();
        tx_enable = 1'b0; irq_enable = 4'h0;
        for (int b = 0; b < DEPTH; b++) write_byte(8'(b), 1'b0);
        check(flags === 4'b1000, "R7", "full flag at depth", flags, 8);
        write_byte(8'hAA, 1'b0);
        check(flags === 4'b1100, "R8", "overrun flag on extra write", flags, 12);
        check(irq === 1'b0, "R10", "irq masked", irq, 0);
        irq_enable = 4'b0100;
        #1;
        check(irq === 1'b1, "R10", "irq unmasked", irq, 1);
        @(negedge clk); flag_clr = 4'b0100;
        @(negedge clk); flag_clr = 4'b0000;
        check(flags === 4'b1000, "R10", "overrun cleared, full kept", flags, 8);
        check(irq === 1'b0, "R10", "irq after clear", irq, 0);

        // R9 low fill crossing
        do_reset();
        tx_enable = 1'b1; crc_enable = 1'b0; upper_thr = CW'(DEPTH); lower_thr = 5'd3;
        irq_enable = 4'h0;
        write_byte(8'h11, 1'b0); write_byte(8'h22, 1'b0); write_byte(8'h33, 1'b0);
        write_byte(8'h44, 1'b0); write_byte(8'h55, 1'b1);
        check(flags[0] === 1'b0, "R9", "no low flag before sending", flags, 0);
        for (int s = 0; s < 80; s++) strobe();
        check(flags[0] === 1'b1, "R9", "low flag after crossing", flags, 1);

        // R12 writes coinciding with byte fetches
        do_reset();
        tx_enable = 1'b1; crc_enable = 1'b1; upper_thr = 5'd2; lower_thr = '0;
        plen = 8;
        for (int b = 0; b < plen; b++) pkt[b] = 8'(b * 37 + 8'h12);
        pkt[1] = 8'h34;
        write_byte(pkt[0], 1'b0);
        write_byte(pkt[1], 1'b0);
        begin
            int nw = 2;
            for (int s = 0; s < 200; s++) begin
                if (s % 6 == 5 && nw < plen) begin
                    strobe_wr(pkt[nw], nw == plen - 1);
                    nw++;
                end else begin
                    strobe();
                end
            end
        end
        build_frame(1'b1);
        compare_frame("R12", "frame with writes during fetch");
        check(flags[1] === 1'b0, "R12", "no underrun while streaming", flags, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule